// File: doc/BRIEF.md
# Zero-Suppressed Hit Readout Serializer

This block turns the hits stored in a chip's per-channel event memories into a stream of 16-bit words on one data line, most significant bit first. After a start pulse it scans the channels from 0 upwards and asks the memories for each channel's event count and stored events. It uses a request and response port, and the response may take any number of cycles. A channel with no events produces no words. For each channel that has events, the block sends a header word with the channel number and the event count, followed by one data word per stored event. Each data word carries the bunch-crossing ID and a 2-bit threshold code.

The chip-ID word always leads the stream. It is held back until the first occupied channel is found, so an empty chip needs no extra pass over the memories. When no channel has events, a configuration bit selects the result: either no bits at all, or the chip-ID word alone. Every word ends in an even-parity bit. A single-cycle completion pulse follows the last bit.

Top module: `rz_readout`

## Requirements
- R1: When any channel has events, the first word sent is the chip-ID word: bit 15 = 0, bits 14:8 = the 7-bit chip ID, and bits 7:1 = 0.
- R2: Every word is 16 bits and is sent most significant bit first, one bit per cycle while `dout_vld` is high. Bit 0 makes the XOR of all 16 bits equal to 0.
- R3: A channel header word has bit 15 = 1, bits 14:9 = the channel number, bits 8:5 = the event count and bits 4:1 = 0.
- R4: A data word has bit 15 = 0, bits 14:3 = the bunch-crossing ID and bits 2:1 = the 2-bit code.
- R5: Channels are visited in ascending order. A channel whose count is 0 sends no words.
- R6: The data words of a channel come straight after its header, in event index order 0 up to count-1.
- R7: With `always_id` = 0 and every count 0, no bit is sent and `done` still pulses.
- R8: With `always_id` = 1 and every count 0, exactly one word, the chip-ID word, is sent.
- R9: `done` is high for exactly one cycle per readout, after the last bit, and `dout_vld` is low in that cycle.
- R10: A `start` pulse during a readout has no effect: the stream is unchanged and no second readout follows.
- R11: After reset, `dout_vld`, `done` and `rd_req` are low.
- R12: A full load of 64 channels holding 8 events each gives 577 words (9232 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a readout pulse (taken only when idle) |
| always_id | input | 1 | 1: an empty chip still sends its ID word |
| chip_id | input | 7 | Chip identifier, latched at start |
| rd_req | output | 1 | Memory read request |
| rd_chan | output | 6 | Channel being read |
| rd_evt | output | 3 | Event index being read |
| rd_vld | input | 1 | Memory response valid |
| rd_cnt | input | 4 | Event count of the requested channel |
| rd_bcid | input | 12 | Bunch-crossing ID of the requested event |
| rd_code | input | 2 | Threshold code of the requested event |
| dout | output | 1 | Serial data |
| dout_vld | output | 1 | Serial data qualifier |
| done | output | 1 | End-of-readout pulse |

## Verification
The number of cycles between words depends on the memory latency, so the bench never checks a word at a fixed cycle. Instead it takes every bit in the cycle where `dout_vld` is high, sampling on the falling clock edge. It then rebuilds the words and compares them with a stream it computes itself from its memory model. The memory model answers one cycle after each `rd_req`. `done` is checked over a window that runs from start until a few cycles after the pulse. In that window the bench counts the pulses and checks that `dout_vld` is low in each of them. For R10, the bench also waits 50 further cycles to confirm that no bits appear after completion.

// File: rtl/rz_pkg.sv
package rz_pkg;
  localparam int WORD_W = 16;
  localparam int ID_W   = 7;
  localparam int CH_W   = 6;
  localparam int CNT_W  = 4;
  localparam int BCID_W = 12;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {WK_ID, WK_HDR, WK_DATA} word_kind_e;
endpackage

// File: rtl/rz_word_fmt.sv
module rz_word_fmt
  import rz_pkg::*;
(
  input  word_kind_e        kind,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [CH_W-1:0]   chan,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BCID_W-1:0] bcid,
  input  logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-2:0] body;

  always_comb begin
    case (kind)
      WK_HDR:  body = {1'b1, chan, cnt, 4'b0000};
      WK_DATA: body = {1'b0, bcid, code};
      default: body = {1'b0, chip_id, 7'b0000000};
    endcase
    word = {body, ^body};
  end
endmodule

// File: rtl/rz_shifter.sv
module rz_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         dout,
  output logic         dout_vld,
  output logic         active,
  output logic         last
);
  localparam int LW = $clog2(W + 1);

  logic [W-1:0]  sreg;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      left     <= '0;
      active   <= 1'b0;
      dout     <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= active;
      if (active) begin
        dout <= sreg[W-1];
        sreg <= sreg << 1;
        left <= left - LW'(1);
        if (left == LW'(1)) active <= 1'b0;
      end else if (load) begin
        sreg   <= word;
        left   <= LW'(W);
        active <= 1'b1;
      end
    end
  end

  assign last = active && (left == LW'(1));

  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    load |-> !active);
  a_r2_even_parity: assert property (@(posedge clk) disable iff (rst)
    load |-> ((^word) == 1'b0));
endmodule

// File: rtl/rz_readout.sv
module rz_readout
  import rz_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int MAX_EVT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       always_id,
  input  logic [ID_W-1:0]            chip_id,
  output logic                       rd_req,
  output logic [CH_W-1:0]            rd_chan,
  output logic [$clog2(MAX_EVT)-1:0] rd_evt,
  input  logic                       rd_vld,
  input  logic [CNT_W-1:0]           rd_cnt,
  input  logic [BCID_W-1:0]          rd_bcid,
  input  logic [CODE_W-1:0]          rd_code,
  output logic                       dout,
  output logic                       dout_vld,
  output logic                       done
);
  localparam int EV_W = $clog2(MAX_EVT);

  typedef enum logic [1:0] {S_IDLE, S_RSP, S_SHIFT, S_FIN} state_e;

  state_e            state;
  logic [CH_W-1:0]   chan;
  logic [EV_W-1:0]   evt;
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   id_q;
  logic              aid_q, id_sent, hdr_sent, fin_pend;
  logic              req_q, done_q;
  logic              ld;
  word_kind_e        kind;
  logic [WORD_W-1:0] word;
  logic              sh_active, sh_last;
  logic              last_ch, last_evt;

  assign last_ch  = (chan == CH_W'(NUM_CH - 1));
  assign last_evt = ((CNT_W'(evt) + CNT_W'(1)) == cnt_q);

  always_comb begin
    ld   = 1'b0;
    kind = WK_ID;
    if (state == S_RSP && rd_vld) begin
      if (hdr_sent || rd_cnt != '0) begin
        ld = 1'b1;
        if (!id_sent)       kind = WK_ID;
        else if (!hdr_sent) kind = WK_HDR;
        else                kind = WK_DATA;
      end
    end else if (state == S_FIN && !id_sent && aid_q) begin
      ld = 1'b1;
    end
  end

  rz_word_fmt u_fmt (
    .kind(kind), .chip_id(id_q), .chan(chan), .cnt(rd_cnt),
    .bcid(rd_bcid), .code(rd_code), .word(word)
  );

  rz_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(ld), .word(word),
    .dout(dout), .dout_vld(dout_vld), .active(sh_active), .last(sh_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      chan     <= '0;
      evt      <= '0;
      cnt_q    <= '0;
      id_q     <= '0;
      aid_q    <= 1'b0;
      id_sent  <= 1'b0;
      hdr_sent <= 1'b0;
      fin_pend <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          chan     <= '0;
          evt      <= '0;
          id_sent  <= 1'b0;
          hdr_sent <= 1'b0;
          fin_pend <= 1'b0;
          aid_q    <= always_id;
          id_q     <= chip_id;
          req_q    <= 1'b1;
          state    <= S_RSP;
        end
        S_RSP: if (rd_vld) begin
          if (!ld) begin
            if (last_ch) state <= S_FIN;
            else begin
              chan  <= chan + CH_W'(1);
              req_q <= 1'b1;
            end
          end else begin
            state <= S_SHIFT;
            if (!id_sent) id_sent <= 1'b1;
            else if (!hdr_sent) begin
              hdr_sent <= 1'b1;
              cnt_q    <= rd_cnt;
              evt      <= '0;
            end else if (last_evt) begin
              hdr_sent <= 1'b0;
              evt      <= '0;
              if (last_ch) fin_pend <= 1'b1;
              else         chan <= chan + CH_W'(1);
            end else begin
              evt <= evt + EV_W'(1);
            end
          end
        end
        S_SHIFT: if (sh_last) begin
          if (fin_pend) state <= S_FIN;
          else begin
            state <= S_RSP;
            req_q <= 1'b1;
          end
        end
        default: begin
          if (ld) begin
            id_sent  <= 1'b1;
            fin_pend <= 1'b1;
            state    <= S_SHIFT;
          end else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign rd_req  = req_q;
  assign rd_chan = chan;
  assign rd_evt  = evt;
  assign done    = done_q;

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !dout_vld);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_id_before_hdr: assert property (@(posedge clk) disable iff (rst)
    (ld && kind == WK_HDR) |-> id_sent);
  a_r5_req_between_words: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !sh_active);
endmodule

// File: tb/rz_readout_tb.sv
`timescale 1ns/1ps
module rz_readout_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, always_id = 1'b0;
  logic [6:0] chip_id = '0;
  logic rd_req, rd_vld;
  logic [5:0] rd_chan;
  logic [2:0] rd_evt;
  logic [3:0] rd_cnt;
  logic [11:0] rd_bcid;
  logic [1:0] rd_code;
  logic dout, dout_vld, done;

  always #2.5 clk = ~clk;

  rz_readout u_dut (
    .clk(clk), .rst(rst), .start(start), .always_id(always_id), .chip_id(chip_id),
    .rd_req(rd_req), .rd_chan(rd_chan), .rd_evt(rd_evt), .rd_vld(rd_vld),
    .rd_cnt(rd_cnt), .rd_bcid(rd_bcid), .rd_code(rd_code),
    .dout(dout), .dout_vld(dout_vld), .done(done)
  );

  logic [3:0]  mcnt  [64];
  logic [11:0] mbcid [64][8];
  logic [1:0]  mcode [64][8];

  always_ff @(posedge clk) begin
    rd_vld  <= rd_req && !rst;
    rd_cnt  <= mcnt[rd_chan];
    rd_bcid <= mbcid[rd_chan][rd_evt];
    rd_code <= mcode[rd_chan][rd_evt];
  end

  logic capbits [10000];
  int nbits = 0, ndone = 0, quiet_bad = 0;
  always @(negedge clk) begin
    if (dout_vld) begin
      if (nbits < 10000) capbits[nbits] = dout;
      nbits++;
    end
    if (done) begin
      ndone++;
      if (dout_vld) quiet_bad++;
    end
  end

  int n_cmp = 0, n_bad = 0;
  logic [15:0] expw [600];
  int nexp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] seal(input logic [14:0] b);
    return {b, ^b};
  endfunction

  task automatic fill(input int ca, input int na, input int cb, input int nb, input bit full);
    for (int c = 0; c < 64; c++) begin
      mcnt[c] = full ? 4'd8 : 4'd0;
      for (int e = 0; e < 8; e++) begin
        mbcid[c][e] = {6'(c), 3'(e), 3'(c + e)};
        mcode[c][e] = 2'(c ^ e);
      end
    end
    if (!full) begin
      mcnt[ca] = 4'(na);
      mcnt[cb] = 4'(nb);
    end
  endtask

  task automatic build_expected(input bit aid, input logic [6:0] id);
    bit any = 0;
    nexp = 0;
    for (int c = 0; c < 64; c++) begin
      if (mcnt[c] != 0) begin
        if (!any) begin
          expw[nexp++] = seal({1'b0, id, 7'b0});
          any = 1;
        end
        expw[nexp++] = seal({1'b1, 6'(c), mcnt[c], 4'b0});
        for (int e = 0; e < int'(mcnt[c]); e++)
          expw[nexp++] = seal({1'b0, mbcid[c][e], mcode[c][e]});
      end
    end
    if (!any && aid) expw[nexp++] = seal({1'b0, id, 7'b0});
  endtask

  task automatic run(input bit aid, input logic [6:0] id, input int nw, input bit restart);
    build_expected(aid, id);
    @(negedge clk);
    nbits = 0; ndone = 0; quiet_bad = 0;
    always_id = aid; chip_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1; always_id = ~aid; chip_id = ~id;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 20000 && ndone == 0; t++) @(negedge clk);
    repeat (50) @(negedge clk);
    chk(nexp == nw, "R5 model word count", nexp, nw);
    chk(nbits == nw * 16, nw == 0 ? "R7 bit count" : (nw == 1 ? "R8 bit count" : "R2 bit count"), nbits, nw * 16);
    if (restart) chk(nbits == nexp * 16, "R10 restart ignored", nbits, nexp * 16);
    if (nw == 577) chk(nbits == 9232, "R12 full load bits", nbits, 9232);
    for (int w = 0; w < nexp && (w + 1) * 16 <= nbits && w * 16 + 15 < 10000; w++) begin
      logic [15:0] g;
      for (int b = 0; b < 16; b++) g[15 - b] = capbits[w * 16 + b];
      chk(g == expw[w], w == 0 ? "R1 lead word" : (expw[w][15] ? "R3 header" : "R4 R6 data"), g, expw[w]);
      chk((^g) == 1'b0, "R2 parity", g, 0);
    end
    chk(ndone == 1, "R9 done count", ndone, 1);
    chk(quiet_bad == 0, "R9 done quiet", quiet_bad, 0);
  endtask

  localparam logic [35:0] TBL [6] = '{
    {6'd5,  4'd1, 6'd40, 4'd3, 1'b0, 7'h62, 8'd7},
    {6'd0,  4'd8, 6'd63, 4'd8, 1'b1, 7'h7F, 8'd19},
    {6'd0,  4'd0, 6'd0,  4'd0, 1'b0, 7'h2A, 8'd0},
    {6'd0,  4'd0, 6'd0,  4'd0, 1'b1, 7'h15, 8'd1},
    {6'd63, 4'd2, 6'd1,  4'd0, 1'b0, 7'h01, 8'd4},
    {6'd20, 4'd1, 6'd43, 4'd1, 1'b1, 7'h33, 8'd5}
  };

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    fill(0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!dout_vld && !done && !rd_req, "R11 reset state", {dout_vld, done, rd_req}, 0);
    for (int i = 0; i < 6; i++) begin
      logic [35:0] v;
      v = TBL[i];
      fill(int'(v[35:30]), int'(v[29:26]), int'(v[25:20]), int'(v[19:16]), 0);
      run(v[15], v[14:8], int'(v[7:0]), 0);
    end
    fill(5, 2, 9, 1, 0);
    run(1'b0, 7'h44, 6, 1);
    fill(0, 0, 0, 0, 1);
    run(1'b0, 7'h5A, 577, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule